// File: doc/BRIEF.md
# Triggered trace capture buffer

This block records a stream of trace words into a circular on-chip memory while capture is enabled. A host loads a post-trigger count beforehand. Until a trigger arrives, words keep flowing into the ring and the oldest entries are overwritten. After the trigger, each stored word lowers the count by one. When the count reaches zero, capture freezes and a completion flag rises. The memory then holds the words that led up to the event, followed by exactly the programmed number of words that came after it.

Readout goes through a pointer register and a data register. Loading the pointer fetches the addressed word into the data register. Each pop strobe consumes the word on view, advances the pointer and fetches the next word ahead of time, so back-to-back pops stream the buffer one word per cycle. While capture is off, the host can also place words into the memory at the write pointer, and it can set that pointer.

Top module: `trace_capture_buffer`

## Requirements
- R1: After reset, `trig_count` is 0, `acq_done` is 0, `buf_full` is 0, `wr_ptr` is 0 and `rd_data` is 0.
- R2: In a cycle where `cap_en`=1, `trc_valid`=1 and `trig_count`≠0, `trc_data` is stored at `wr_ptr` and `wr_ptr` is one higher after the next clock edge. A cycle with `trc_valid`=0 stores nothing.
- R3: While no trigger has been latched, `trig_count` holds its value while words are being stored.
- R4: Once `trig_in` has been seen during capture with a nonzero count, `trig_count` drops by one for every word stored. The first decrement applies to a word stored in the same cycle as the trigger.
- R5: When `trig_count` reaches zero through a decrement, `acq_done` becomes 1 and no further trace words are stored (`wr_ptr` holds).
- R6: A count of N leaves exactly N words stored from the trigger word onward, the trigger word included. N=1 finishes on the trigger word itself.
- R7: `wr_ptr` wraps from DEPTH-1 to 0. A trace store that wraps it sets `buf_full`.
- R8: A rising edge of `cap_en` clears `acq_done` and `buf_full` on the next edge and leaves `wr_ptr` unchanged.
- R9: A `trig_in` pulse while `trig_count` is 0 is ignored. If a count is loaded afterwards, words stored later do not lower it.
- R10: `rptr_load` loads the read pointer and places the word at that address in `rd_data` after the edge. Each `rd_pop` places the word at pointer+1 (modulo DEPTH) in `rd_data` after the edge.
- R11: With `cap_en`=0, `wptr_load` sets `wr_ptr`, and `host_wr` stores `host_wdata` at `wr_ptr` and advances it. With `cap_en`=1, both are ignored and neither the memory nor `wr_ptr` changes.
- R12: `cnt_load` sets `trig_count` to `cnt_load_val` on the next edge, and takes priority over a decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | 1 | Capture enable level |
| trc_valid | input | 1 | Trace word valid this cycle |
| trc_data | input | DATA_W | Trace word |
| trig_in | input | 1 | Trigger event pulse |
| cnt_load | input | 1 | Load post-trigger count |
| cnt_load_val | input | CNT_W | Count value to load |
| wptr_load | input | 1 | Set write pointer (capture off) |
| wptr_load_val | input | ADDR_W | Write pointer value |
| host_wr | input | 1 | Host memory write strobe (capture off) |
| host_wdata | input | DATA_W | Host write word |
| rptr_load | input | 1 | Load read pointer and prefetch |
| rptr_load_val | input | ADDR_W | Read pointer value |
| rd_pop | input | 1 | Consume data register and fetch next word |
| rd_data | output | DATA_W | Data register |
| trig_count | output | CNT_W | Current post-trigger count |
| acq_done | output | 1 | Acquisition complete |
| buf_full | output | 1 | Write pointer has wrapped during capture |
| wr_ptr | output | ADDR_W | Current write pointer |

## Verification
Every control strobe and every stored word takes effect on the first clock edge after the cycle in which it is presented. `wr_ptr`, `trig_count`, `acq_done`, `buf_full` and `rd_data` therefore show the new value one edge later, with no additional latency. The bench drives inputs on the falling edge. It advances a behavioural model on the rising edge using those same inputs, and compares all outputs against it on the next falling edge, half a cycle after the update. Where `rd_data` is compared, it is compared only after a pointer load that no memory write has followed since.

// File: rtl/tcb_pkg.sv
package tcb_pkg;
   typedef enum logic [1:0] {
      WSRC_NONE  = 2'd0,
      WSRC_TRACE = 2'd1,
      WSRC_HOST  = 2'd2
   } wsrc_e;
endpackage

// File: rtl/tcb_ram.sv
module tcb_ram #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tcb_trig_ctl.sv
module tcb_trig_ctl #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic             cap_rise,
   input  logic             trace_wr,
   input  logic             trig_in,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             cnt_nz,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;
   logic             trig_q;
   logic             done_q;
   logic             dec;
   logic             fin;

   assign cnt_nz = (cnt_q != '0);
   assign dec    = trace_wr && (trig_q || trig_in);
   assign fin    = dec && (cnt_q == CNT_W'(1)) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trig_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (load)     cnt_q <= load_val;
         else if (dec) cnt_q <= cnt_q - CNT_W'(1);

         if (fin)           done_q <= 1'b1;
         else if (cap_rise) done_q <= 1'b0;

         if (fin)                                trig_q <= 1'b0;
         else if (trig_in && cap_en && cnt_nz)   trig_q <= 1'b1;
         else if (cap_rise)                      trig_q <= 1'b0;
      end
   end

   assign cnt  = cnt_q;
   assign done = done_q;

   // R3
   hold_before_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_q && !trig_in && !load) |=> (cnt_q == $past(cnt_q)));
   // R4
   dec_per_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !load) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   // R5
   done_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> (cnt_q == '0));
   // R9
   zero_trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_in && !cnt_nz && !trig_q) |=> !trig_q);
endmodule

// File: rtl/tcb_wptr.sv
module tcb_wptr #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_rise,
   input  logic              trace_wr,
   input  logic              host_wr,
   input  logic              set,
   input  logic [ADDR_W-1:0] set_val,
   output logic [ADDR_W-1:0] wp,
   output logic              full
);
   localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

   logic [ADDR_W-1:0] wp_q;
   logic              full_q;
   logic              adv;

   assign adv = trace_wr || host_wr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q   <= '0;
         full_q <= 1'b0;
      end else begin
         if (set)      wp_q <= set_val;
         else if (adv) wp_q <= wp_q + ADDR_W'(1);

         if (trace_wr && wp_q == LAST) full_q <= 1'b1;
         else if (cap_rise)            full_q <= 1'b0;
      end
   end

   assign wp   = wp_q;
   assign full = full_q;

   // R2
   wp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_wr && !set) |=> (wp_q == $past(wp_q) + ADDR_W'(1)));
   // R7
   wrap_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trace_wr && wp_q == LAST) |=> (wp_q == '0 && full_q));
   // R8
   rise_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_rise && !trace_wr) |=> !full_q);
endmodule

// File: rtl/tcb_readout.sv
module tcb_readout #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ptr_load,
   input  logic [ADDR_W-1:0] ptr_val,
   input  logic              pop,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [ADDR_W-1:0] ram_raddr,
   output logic [DATA_W-1:0] dreg
);
   logic [ADDR_W-1:0] rp_q;
   logic [DATA_W-1:0] dreg_q;

   assign ram_raddr = ptr_load ? ptr_val : rp_q + ADDR_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rp_q   <= '0;
         dreg_q <= '0;
      end else if (ptr_load) begin
         rp_q   <= ptr_val;
         dreg_q <= ram_rdata;
      end else if (pop) begin
         rp_q   <= rp_q + ADDR_W'(1);
         dreg_q <= ram_rdata;
      end
   end

   assign dreg = dreg_q;

   // R10
   pop_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !ptr_load) |=> (rp_q == $past(rp_q) + ADDR_W'(1)));
   // R10
   load_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load |=> (rp_q == $past(ptr_val)));
endmodule

// File: rtl/trace_capture_buffer.sv
module trace_capture_buffer
   import tcb_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 4,
   parameter int CNT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic              trc_valid,
   input  logic [DATA_W-1:0] trc_data,
   input  logic              trig_in,
   input  logic              cnt_load,
   input  logic [CNT_W-1:0]  cnt_load_val,
   input  logic              wptr_load,
   input  logic [ADDR_W-1:0] wptr_load_val,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              rptr_load,
   input  logic [ADDR_W-1:0] rptr_load_val,
   input  logic              rd_pop,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  trig_count,
   output logic              acq_done,
   output logic              buf_full,
   output logic [ADDR_W-1:0] wr_ptr
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be at least 1");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 1..12");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
   endgenerate

   logic              cap_q;
   logic              cap_rise;
   logic              cnt_nz;
   logic              trace_go;
   logic              host_go;
   logic              wp_set;
   wsrc_e             wsrc;
   logic [DATA_W-1:0] ram_wdata;
   logic [ADDR_W-1:0] ram_raddr;
   logic [DATA_W-1:0] ram_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) cap_q <= 1'b0;
      else        cap_q <= cap_en;
   end

   assign cap_rise = cap_en && !cap_q;
   assign trace_go = cap_en && trc_valid && cnt_nz;
   assign wp_set   = !cap_en && wptr_load;
   assign host_go  = !cap_en && host_wr && !wptr_load;

   always_comb begin
      if (trace_go)     wsrc = WSRC_TRACE;
      else if (host_go) wsrc = WSRC_HOST;
      else              wsrc = WSRC_NONE;
   end

   always_comb begin
      case (wsrc)
         WSRC_TRACE: ram_wdata = trc_data;
         WSRC_HOST:  ram_wdata = host_wdata;
         default:    ram_wdata = '0;
      endcase
   end

   tcb_trig_ctl #(.CNT_W(CNT_W)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .cap_rise (cap_rise),
      .trace_wr (trace_go),
      .trig_in  (trig_in),
      .load     (cnt_load),
      .load_val (cnt_load_val),
      .cnt      (trig_count),
      .cnt_nz   (cnt_nz),
      .done     (acq_done)
   );

   tcb_wptr #(.ADDR_W(ADDR_W)) u_wptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_rise (cap_rise),
      .trace_wr (trace_go),
      .host_wr  (host_go),
      .set      (wp_set),
      .set_val  (wptr_load_val),
      .wp       (wr_ptr),
      .full     (buf_full)
   );

   tcb_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk   (clk),
      .we    (wsrc != WSRC_NONE),
      .waddr (wr_ptr),
      .wdata (ram_wdata),
      .raddr (ram_raddr),
      .rdata (ram_rdata)
   );

   tcb_readout #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_load  (rptr_load),
      .ptr_val   (rptr_load_val),
      .pop       (rd_pop),
      .ram_rdata (ram_rdata),
      .ram_raddr (ram_raddr),
      .dreg      (rd_data)
   );

   // R5
   frozen_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acq_done && !cnt_load && !wp_set && !host_go) |=> $stable(wr_ptr));
   // R11
   host_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && host_wr && !trace_go) |=> $stable(wr_ptr));
   // R8
   rise_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_rise && !trace_go) |=> !acq_done);
endmodule

// File: tb/trace_capture_buffer_test.sv
module trace_capture_buffer_test;
   localparam int DW    = 16;
   localparam int AW    = 4;
   localparam int CW    = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cap_en = 1'b0;
   logic          trc_valid = 1'b0;
   logic [DW-1:0] trc_data = '0;
   logic          trig_in = 1'b0;
   logic          cnt_load = 1'b0;
   logic [CW-1:0] cnt_load_val = '0;
   logic          wptr_load = 1'b0;
   logic [AW-1:0] wptr_load_val = '0;
   logic          host_wr = 1'b0;
   logic [DW-1:0] host_wdata = '0;
   logic          rptr_load = 1'b0;
   logic [AW-1:0] rptr_load_val = '0;
   logic          rd_pop = 1'b0;
   logic [DW-1:0] rd_data;
   logic [CW-1:0] trig_count;
   logic          acq_done;
   logic          buf_full;
   logic [AW-1:0] wr_ptr;

   int checks = 0;
   int failures = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   trace_capture_buffer #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .trc_valid(trc_valid),
      .trc_data(trc_data), .trig_in(trig_in), .cnt_load(cnt_load),
      .cnt_load_val(cnt_load_val), .wptr_load(wptr_load),
      .wptr_load_val(wptr_load_val), .host_wr(host_wr),
      .host_wdata(host_wdata), .rptr_load(rptr_load),
      .rptr_load_val(rptr_load_val), .rd_pop(rd_pop), .rd_data(rd_data),
      .trig_count(trig_count), .acq_done(acq_done), .buf_full(buf_full),
      .wr_ptr(wr_ptr)
   );

   // behavioural reference
   int mem [DEPTH];
   int m_wp = 0, m_cnt = 0, m_rp = 0, m_rd = 0;
   bit m_trig = 0, m_done = 0, m_full = 0, m_capq = 0, m_rv = 0, m_live = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_wp = 0; m_cnt = 0; m_rp = 0; m_rd = 0;
         m_trig = 0; m_done = 0; m_full = 0; m_capq = 0; m_rv = 0;
         m_live = 1;
      end else begin
         bit rise, go, dec, fin, hgo;
         rise = cap_en && !m_capq;
         go   = cap_en && trc_valid && (m_cnt != 0);
         dec  = go && (m_trig || trig_in);
         fin  = dec && (m_cnt == 1) && !cnt_load;
         hgo  = !cap_en && host_wr && !wptr_load;
         if (rptr_load) begin
            m_rp = rptr_load_val; m_rd = mem[m_rp]; m_rv = 1;
         end else if (rd_pop) begin
            m_rp = (m_rp + 1) % DEPTH; m_rd = mem[m_rp];
         end
         if (go || hgo) m_rv = m_rv && rptr_load ? 1 : 0;
         if (go) mem[m_wp] = trc_data;
         else if (hgo) mem[m_wp] = host_wdata;
         if (go && m_wp == DEPTH - 1) m_full = 1;
         else if (rise) m_full = 0;
         if (!cap_en && wptr_load) m_wp = wptr_load_val;
         else if (go || hgo) m_wp = (m_wp + 1) % DEPTH;
         if (fin) m_trig = 0;
         else if (trig_in && cap_en && m_cnt != 0) m_trig = 1;
         else if (rise) m_trig = 0;
         if (fin) m_done = 1;
         else if (rise) m_done = 0;
         if (cnt_load) m_cnt = cnt_load_val;
         else if (dec) m_cnt = m_cnt - 1;
         m_capq = cap_en;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (m_live && rst_n && !finished) begin
         chk("R2 model wr_ptr", int'(wr_ptr), m_wp);
         chk("R4 model trig_count", int'(trig_count), m_cnt);
         chk("R5 model acq_done", int'(acq_done), int'(m_done));
         chk("R7 model buf_full", int'(buf_full), int'(m_full));
         if (m_rv && !cap_en) chk("R10 model rd_data", int'(rd_data), m_rd);
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic word(input logic [DW-1:0] d, input logic trg);
      trc_valid = 1'b1; trc_data = d; trig_in = trg;
      tick();
      trc_valid = 1'b0; trig_in = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog actual=running expected=finished");
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R1 reset state
      chk("R1 trig_count", int'(trig_count), 0);
      chk("R1 acq_done", int'(acq_done), 0);
      chk("R1 buf_full", int'(buf_full), 0);
      chk("R1 wr_ptr", int'(wr_ptr), 0);
      chk("R1 rd_data", int'(rd_data), 0);
      rst_n = 1'b1;
      tick();

      // R11 host fill with capture off
      wptr_load = 1'b1; wptr_load_val = 4'd0; tick(); wptr_load = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         host_wr = 1'b1; host_wdata = DW'(16'h1000 + i); tick();
      end
      host_wr = 1'b0;
      chk("R11 wr_ptr after fill", int'(wr_ptr), 0);
      chk("R7 host wrap leaves full clear", int'(buf_full), 0);

      // R10 readout with wrap of the read pointer
      rptr_load = 1'b1; rptr_load_val = 4'd14; tick(); rptr_load = 1'b0;
      chk("R10 first word", int'(rd_data), 16'h100E);
      rd_pop = 1'b1; tick();
      chk("R10 pop 15", int'(rd_data), 16'h100F);
      tick();
      chk("R10 pop wraps to 0", int'(rd_data), 16'h1000);
      rd_pop = 1'b0;

      // R12 count load
      cnt_load = 1'b1; cnt_load_val = 8'd5; tick(); cnt_load = 1'b0;
      chk("R12 trig_count", int'(trig_count), 5);

      // R3 pre-trigger capture, gaps included
      cap_en = 1'b1;
      for (int i = 0; i < 7; i++) begin
         word(DW'(16'hA000 + i), 1'b0);
         tick();
      end
      chk("R3 count holds", int'(trig_count), 5);
      chk("R2 wr_ptr after 7 words", int'(wr_ptr), 7);

      // R4 trigger word counts
      word(16'hA007, 1'b1);
      chk("R4 first decrement", int'(trig_count), 4);
      for (int i = 8; i < 12; i++) word(DW'(16'hA000 + i), 1'b0);
      chk("R5 done set", int'(acq_done), 1);
      chk("R5 count zero", int'(trig_count), 0);
      chk("R6 five words kept", int'(wr_ptr), 12);
      word(16'hBEEF, 1'b0);
      word(16'hBEEF, 1'b1);
      chk("R5 no store after done", int'(wr_ptr), 12);

      // R11 host write ignored while enabled
      host_wr = 1'b1; host_wdata = 16'hDEAD; tick(); host_wr = 1'b0;
      chk("R11 wr_ptr unchanged", int'(wr_ptr), 12);

      cap_en = 1'b0; tick();
      rptr_load = 1'b1; rptr_load_val = 4'd7; tick(); rptr_load = 1'b0;
      chk("R6 trigger word", int'(rd_data), 16'hA007);
      rptr_load = 1'b1; rptr_load_val = 4'd11; tick(); rptr_load = 1'b0;
      chk("R6 last word", int'(rd_data), 16'hA00B);
      rd_pop = 1'b1; tick(); rd_pop = 1'b0;
      chk("R11 memory untouched", int'(rd_data), 16'h100C);

      // R8 re-enable clears done and keeps wr_ptr
      cap_en = 1'b1; tick();
      chk("R8 done cleared", int'(acq_done), 0);
      chk("R8 wr_ptr kept", int'(wr_ptr), 12);

      // R9 trigger at zero ignored
      trig_in = 1'b1; tick(); trig_in = 1'b0;
      cnt_load = 1'b1; cnt_load_val = 8'd3; tick(); cnt_load = 1'b0;
      for (int i = 0; i < 20; i++) word(DW'(16'hC000 + i), 1'b0);
      chk("R9 count still 3", int'(trig_count), 3);
      chk("R7 wr_ptr wrapped", int'(wr_ptr), 0);
      chk("R7 full set", int'(buf_full), 1);

      // R8 new run clears full
      cap_en = 1'b0; tick();
      cap_en = 1'b1; tick();
      chk("R8 full cleared", int'(buf_full), 0);
      chk("R8 wr_ptr kept after rise", int'(wr_ptr), 0);

      // R6 count of one ends on trigger word
      cnt_load = 1'b1; cnt_load_val = 8'd1; tick(); cnt_load = 1'b0;
      word(16'hD001, 1'b1);
      chk("R6 single word done", int'(acq_done), 1);
      chk("R6 single word ptr", int'(wr_ptr), 1);
      cap_en = 1'b0; tick(); tick();

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule